// File: doc/BRIEF.md
# Cache Admission Filter with Write-Burst Reinsertion Blocker

This block sits beside a wear-limited cache and decides, for each line pushed down by an eviction from the level above, whether that line should be written into the cache. Each candidate carries its line address, a dirty flag, a flag saying it came from the instruction-side cache, and the number of reads and writes it received while it was resident above. A three-bit selector picks one of eight admission rules. The rules range from fixed (take everything, take nothing) through counter thresholds to probabilistic admission.

Two of the rules also consult a single-hash Bloom filter. The filter is trained by the cache. When the cache forces a line out because it was written too often, it reports that address here. The filter then records it with a programmable probability. Later candidates whose filter bit is set are refused, so lines that churn do not keep coming back. A built-in 16-bit LFSR supplies every random draw. A clear request wipes the filter one bit per cycle while a busy flag is raised.

The verdict is registered and appears one cycle after the candidate strobe.

Top module: `adm_filter`

## Requirements
- R1: `dec_valid` is high exactly in the cycle after a cycle with `cand_valid` high. `dec_admit` is low whenever `dec_valid` is low.
- R2: Policy code 0 admits every candidate. Policy code 1 admits none.
- R3: Policy code 2 admits a candidate only when `cand_icache` is 1.
- R4: Policy code 3 admits a candidate only when `cand_reads` >= `read_thr`.
- R5: Policy code 4 admits a candidate only when `cand_writes` < `write_thr`.
- R6: The LFSR resets to 16'hACE1. On each clock edge where `cand_valid` or `fevict_valid` is high, it shifts left and takes in bit15^bit13^bit12^bit10 as the new bit 0. A draw succeeds when the value before the shift, taken modulo 100, is below the percentage used. Policy code 5 admits on a successful draw against `admit_pct`.
- R7: The filter index is formed by XOR-folding the address. Index bit j is the XOR of every address bit i with i mod log2(BLOOM_BITS) = j.
- R8: When `fevict_valid` is high, `busy` is low and a draw against `block_pct` succeeds, the filter bit at the hashed address is set at that edge. A candidate in a later cycle then sees that bit.
- R9: Policy code 6 rejects a candidate whose filter bit is set, and rejects any candidate while `busy` is high. Otherwise it admits on a successful draw against `admit_pct`.
- R10: Policy code 7 behaves like code 6 and in addition rejects every candidate with `cand_dirty` = 1.
- R11: A `clear_req` while `busy` is low raises `busy` for exactly BLOOM_BITS cycles and leaves every filter bit zero. A `clear_req` while busy is ignored. Force-evict training is ignored while busy.
- R12: After reset, `dec_valid`, `dec_admit` and `busy` are low and every filter bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Candidate strobe |
| cand_addr | input | ADDR_W | Candidate line address |
| cand_dirty | input | 1 | Candidate was modified |
| cand_icache | input | 1 | Candidate came from the instruction-side cache |
| cand_reads | input | CNT_W | Reads seen while resident above |
| cand_writes | input | CNT_W | Writes seen while resident above |
| policy | input | 3 | Admission rule select, codes 0 to 7 |
| read_thr | input | CNT_W | Read-count threshold |
| write_thr | input | CNT_W | Write-count threshold |
| admit_pct | input | 7 | Admission probability in percent |
| block_pct | input | 7 | Filter training probability in percent |
| fevict_valid | input | 1 | Cache reports a write-forced eviction |
| fevict_addr | input | ADDR_W | Address of the forced-out line |
| clear_req | input | 1 | Start wiping the filter |
| busy | output | 1 | Filter wipe in progress |
| dec_valid | output | 1 | Verdict strobe |
| dec_admit | output | 1 | Verdict: 1 means write the line into the cache |

## Verification
The bench builds the block with a 16-bit address, a 64-bit filter and 4-bit counters. A 64-entry table lets a small pool of addresses collide and set bits quickly. It also makes a full wipe short enough that several clears, including clears requested while already busy, fit inside a random run. The 4-bit counters let the read and write thresholds be driven to their equality and off-by-one edges, and to the extremes 0 and 15, many times per run. The filter bits and the LFSR stream are modelled in the bench, so every random verdict is predicted exactly.

// File: rtl/adm_pkg.sv
package adm_pkg;

   typedef enum logic [2:0] {
      POL_ALL    = 3'd0,
      POL_NONE   = 3'd1,
      POL_INSTR  = 3'd2,
      POL_READ   = 3'd3,
      POL_WRITE  = 3'd4,
      POL_RAND   = 3'd5,
      POL_BLOOM  = 3'd6,
      POL_CBLOOM = 3'd7
   } adm_policy_e;

   localparam int          LFSR_W    = 16;
   localparam logic [15:0] LFSR_SEED = 16'hACE1;

   // Percentage draw: LFSR value modulo 100 below the setting.
   function automatic logic pct_hit(input logic [15:0] v, input logic [6:0] pct);
      return (v % 16'd100) < {9'd0, pct};
   endfunction

endpackage

// File: rtl/adm_lfsr.sv
module adm_lfsr
   import adm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [LFSR_W-1:0] value
);

   logic fb;
   assign fb = value[15] ^ value[13] ^ value[12] ^ value[10];

   always_ff @(posedge clk) begin
      if (!rst_n)   value <= LFSR_SEED;
      else if (adv) value <= {value[LFSR_W-2:0], fb};
   end

   // R6
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      value != '0);

   // R6
   lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(value));

endmodule

// File: rtl/adm_bloom.sv
module adm_bloom #(
   parameter int ADDR_W     = 32,
   parameter int BLOOM_BITS = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] look_addr,
   input  logic              ins_req,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic              clr_req,
   output logic              hit,
   output logic              busy
);

   localparam int IDX_W = $clog2(BLOOM_BITS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOOM_BITS - 1);

   generate
      if (BLOOM_BITS < 2 || (BLOOM_BITS & (BLOOM_BITS - 1)) != 0) begin : g_bad_bits
         $error("adm_bloom: BLOOM_BITS must be a power of two of at least 2");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("adm_bloom: ADDR_W must cover the table index");
      end
   endgenerate

   function automatic logic [IDX_W-1:0] fold(input logic [ADDR_W-1:0] a);
      logic [IDX_W-1:0] h;
      h = '0;
      for (int i = 0; i < ADDR_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ a[i];
      return h;
   endfunction

   logic [BLOOM_BITS-1:0] tbl;
   logic [IDX_W-1:0]      ptr;
   logic [IDX_W-1:0]      look_idx, ins_idx;
   logic                  ins_en;

   assign look_idx = fold(look_addr);
   assign ins_idx  = fold(ins_addr);
   assign ins_en   = ins_req && !busy;
   assign hit      = tbl[look_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= '0;
      end else if (busy) begin
         if (ptr == LAST) busy <= 1'b0;
         else             ptr  <= ptr + 1'b1;
      end else if (clr_req) begin
         busy <= 1'b1;
         ptr  <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl <= '0;
      end else begin
         for (int i = 0; i < BLOOM_BITS; i++) begin
            if (busy && ptr == IDX_W'(i))            tbl[i] <= 1'b0;
            else if (ins_en && ins_idx == IDX_W'(i)) tbl[i] <= 1'b1;
         end
      end
   end

   // R11
   clr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req && !busy |=> busy);

   // R11
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> tbl == '0);

   // R8
   ins_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |=> tbl[$past(ins_idx)]);

endmodule

// File: rtl/adm_filter.sv
module adm_filter
   import adm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BLOOM_BITS = 1024,
   parameter int CNT_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid,
   input  logic [ADDR_W-1:0] cand_addr,
   input  logic              cand_dirty,
   input  logic              cand_icache,
   input  logic [CNT_W-1:0]  cand_reads,
   input  logic [CNT_W-1:0]  cand_writes,
   input  logic [2:0]        policy,
   input  logic [CNT_W-1:0]  read_thr,
   input  logic [CNT_W-1:0]  write_thr,
   input  logic [6:0]        admit_pct,
   input  logic [6:0]        block_pct,
   input  logic              fevict_valid,
   input  logic [ADDR_W-1:0] fevict_addr,
   input  logic              clear_req,
   output logic              busy,
   output logic              dec_valid,
   output logic              dec_admit
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("adm_filter: CNT_W must be at least 1");
      end
   endgenerate

   logic [LFSR_W-1:0] rnd;
   logic              bloom_hit;
   logic              draw_admit, draw_block;
   logic              admit_c;
   adm_policy_e       pol;

   assign pol        = adm_policy_e'(policy);
   assign draw_admit = pct_hit(rnd, admit_pct);
   assign draw_block = pct_hit(rnd, block_pct);

   adm_lfsr u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (cand_valid | fevict_valid),
      .value (rnd)
   );

   adm_bloom #(
      .ADDR_W     (ADDR_W),
      .BLOOM_BITS (BLOOM_BITS)
   ) u_bloom (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_addr (cand_addr),
      .ins_req   (fevict_valid & draw_block),
      .ins_addr  (fevict_addr),
      .clr_req   (clear_req),
      .hit       (bloom_hit),
      .busy      (busy)
   );

   always_comb begin
      unique case (pol)
         POL_ALL:    admit_c = 1'b1;
         POL_NONE:   admit_c = 1'b0;
         POL_INSTR:  admit_c = cand_icache;
         POL_READ:   admit_c = cand_reads >= read_thr;
         POL_WRITE:  admit_c = cand_writes < write_thr;
         POL_RAND:   admit_c = draw_admit;
         POL_BLOOM:  admit_c = !busy && !bloom_hit && draw_admit;
         POL_CBLOOM: admit_c = !busy && !bloom_hit && draw_admit && !cand_dirty;
         default:    admit_c = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_admit <= 1'b0;
      end else begin
         dec_valid <= cand_valid;
         dec_admit <= cand_valid & admit_c;
      end
   end

   // R1
   dec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |=> dec_valid);

   // R1
   admit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_admit);

   // R2
   none_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && policy == 3'd1 |=> !dec_admit);

   // R9
   bloom_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && policy == 3'd6 && (bloom_hit || busy) |=> !dec_admit);

   // R10
   clean_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && policy == 3'd7 && cand_dirty |=> !dec_admit);

endmodule

// File: tb/adm_filter_tb.sv
module adm_filter_tb;

   localparam int AW = 16;
   localparam int NB = 64;
   localparam int IW = 6;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cand_valid = 1'b0;
   logic [AW-1:0] cand_addr = '0;
   logic          cand_dirty = 1'b0;
   logic          cand_icache = 1'b0;
   logic [CW-1:0] cand_reads = '0;
   logic [CW-1:0] cand_writes = '0;
   logic [2:0]    policy = '0;
   logic [CW-1:0] read_thr = '0;
   logic [CW-1:0] write_thr = '0;
   logic [6:0]    admit_pct = '0;
   logic [6:0]    block_pct = '0;
   logic          fevict_valid = 1'b0;
   logic [AW-1:0] fevict_addr = '0;
   logic          clear_req = 1'b0;
   logic          busy, dec_valid, dec_admit;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // reference model state
   logic [15:0] m_lfsr;
   logic [NB-1:0] m_tbl;
   bit  m_busy;
   int  m_ptr;

   always #4 clk = ~clk;

   adm_filter #(.ADDR_W(AW), .BLOOM_BITS(NB), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_addr(cand_addr),
      .cand_dirty(cand_dirty), .cand_icache(cand_icache), .cand_reads(cand_reads),
      .cand_writes(cand_writes), .policy(policy), .read_thr(read_thr),
      .write_thr(write_thr), .admit_pct(admit_pct), .block_pct(block_pct),
      .fevict_valid(fevict_valid), .fevict_addr(fevict_addr), .clear_req(clear_req),
      .busy(busy), .dec_valid(dec_valid), .dec_admit(dec_admit)
   );

   function automatic logic [IW-1:0] hash_of(input logic [AW-1:0] a);
      logic [IW-1:0] h;
      h = '0;
      for (int i = 0; i < AW; i++) h[i % IW] ^= a[i];
      return h;
   endfunction

   function automatic bit drawn(input logic [15:0] v, input int pct);
      return (int'(v) % 100) < pct;
   endfunction

   function automatic logic [15:0] lfsr_next(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   function automatic bit expect_admit();
      bit d, h;
      d = drawn(m_lfsr, int'(admit_pct));
      h = m_tbl[hash_of(cand_addr)];
      case (policy)
         3'd0: return 1'b1;
         3'd1: return 1'b0;
         3'd2: return cand_icache;
         3'd3: return cand_reads >= read_thr;
         3'd4: return cand_writes < write_thr;
         3'd5: return d;
         3'd6: return !m_busy && !h && d;
         default: return !m_busy && !h && d && !cand_dirty;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] p);
      case (p)
         3'd0, 3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R9 (R7 R8)";
         default: return "R10 (R7 R8)";
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // One cycle: inputs are already set at a falling edge.
   task automatic tick();
      bit e_v, e_a, s_fev, s_clr, s_adv, ins;
      logic [AW-1:0] s_faddr;
      string t;
      check("R11 busy", int'(busy), int'(m_busy));
      e_v = cand_valid;
      e_a = e_v && expect_admit();
      t = tag_of(policy);
      s_fev = fevict_valid; s_faddr = fevict_addr; s_clr = clear_req;
      s_adv = cand_valid || fevict_valid;
      ins = s_fev && drawn(m_lfsr, int'(block_pct));
      @(posedge clk);
      @(negedge clk);
      check("R1 dec_valid", int'(dec_valid), int'(e_v));
      if (e_v) check(t, int'(dec_admit), int'(e_a));
      else     check("R1 idle admit", int'(dec_admit), 0);
      if (m_busy) begin
         m_tbl[m_ptr] = 1'b0;
         if (m_ptr == NB - 1) m_busy = 1'b0;
         else m_ptr++;
      end else begin
         if (ins) m_tbl[hash_of(s_faddr)] = 1'b1;
         if (s_clr) begin m_busy = 1'b1; m_ptr = 0; end
      end
      if (s_adv) m_lfsr = lfsr_next(m_lfsr);
   endtask

   task automatic idle_inputs();
      cand_valid = 1'b0; fevict_valid = 1'b0; clear_req = 1'b0;
   endtask

   task automatic cand(input logic [2:0] p, input logic [AW-1:0] a, input bit dirty);
      idle_inputs();
      cand_valid = 1'b1; policy = p; cand_addr = a; cand_dirty = dirty;
      tick();
   endtask

   initial begin
      logic [AW-1:0] pool [8];
      m_lfsr = 16'hACE1; m_tbl = '0; m_busy = 1'b0; m_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      check("R12 dec_valid", int'(dec_valid), 0);
      check("R12 dec_admit", int'(dec_admit), 0);
      check("R12 busy", int'(busy), 0);

      // R2, R3 fixed rules
      admit_pct = 7'd100; block_pct = 7'd100;
      cand(3'd0, 16'h0011, 1'b1);
      cand(3'd1, 16'h0011, 1'b0);
      cand_icache = 1'b1; cand(3'd2, 16'h0012, 1'b0);
      cand_icache = 1'b0; cand(3'd2, 16'h0012, 1'b0);

      // R4 and R5 threshold edges
      read_thr = 4'd5;
      cand_reads = 4'd5; cand(3'd3, 16'h0020, 1'b0);
      cand_reads = 4'd4; cand(3'd3, 16'h0020, 1'b0);
      read_thr = 4'd0; cand_reads = 4'd0; cand(3'd3, 16'h0020, 1'b0);
      write_thr = 4'd3;
      cand_writes = 4'd3; cand(3'd4, 16'h0021, 1'b0);
      cand_writes = 4'd2; cand(3'd4, 16'h0021, 1'b0);
      write_thr = 4'd0; cand_writes = 4'd0; cand(3'd4, 16'h0021, 1'b0);

      // R8 training then R9 blocking of the same address
      idle_inputs(); fevict_valid = 1'b1; fevict_addr = 16'h1234; tick();
      cand(3'd6, 16'h1234, 1'b0);
      cand(3'd6, 16'h1235, 1'b0);
      // R10 dirty rejection and clean admission
      cand(3'd7, 16'h0001, 1'b1);
      cand(3'd7, 16'h0001, 1'b0);

      // R11 wipe, second request while busy, training while busy
      idle_inputs(); clear_req = 1'b1; tick();
      idle_inputs(); clear_req = 1'b1; tick();
      idle_inputs(); fevict_valid = 1'b1; fevict_addr = 16'h0777; tick();
      for (int k = 0; k < NB; k++) cand(3'd6, 16'h1234, 1'b0);
      cand(3'd6, 16'h1234, 1'b0);
      cand(3'd6, 16'h0777, 1'b0);

      // R6 random admission with several settings
      admit_pct = 7'd0;  cand(3'd5, 16'h0005, 1'b0);
      admit_pct = 7'd37; for (int k = 0; k < 20; k++) cand(3'd5, 16'h0005, 1'b0);

      // constrained random run
      void'($urandom(32'd2024));
      for (int k = 0; k < 8; k++) pool[k] = 16'($urandom);
      for (int k = 0; k < 4000; k++) begin
         int r;
         idle_inputs();
         cand_valid   = ($urandom % 4) != 0;
         fevict_valid = ($urandom % 3) == 0;
         clear_req    = ($urandom % 300) == 0;
         policy       = 3'($urandom);
         cand_addr    = pool[$urandom % 8];
         fevict_addr  = pool[$urandom % 8];
         cand_dirty   = 1'($urandom);
         cand_icache  = 1'($urandom);
         cand_reads   = 4'($urandom);
         cand_writes  = 4'($urandom);
         read_thr     = 4'($urandom);
         write_thr    = 4'($urandom);
         r = $urandom % 4;
         admit_pct    = (r == 0) ? 7'd0 : (r == 1) ? 7'd100 : 7'($urandom % 101);
         block_pct    = 7'($urandom % 101);
         tick();
      end
      idle_inputs();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule